// File: doc/BRIEF.md
# Code-Density Bin Calibration Unit

This block calibrates the fine codes of a single tapped-delay-line time measurement channel. Real delay lines have taps of unequal width: some taps may collect no hits at all, while others may be two or three times the nominal size. Assuming one fixed step per tap therefore gives the wrong answer. The block instead measures the width of every bin. Each system that has several chains places one instance per chain, and each instance holds its own table.

Calibration starts on a rising edge of the mode input. The unit clears a histogram and then counts hits whose timing is uncorrelated with the system clock, until exactly 2^k hits have arrived. The exponent k is supplied at start. In a single sequential pass over the codes, it then turns each bin count into a width equal to count × clock period / 2^k picoseconds. It writes a table that places every code at the middle of its own measured bin. In run mode, each valid raw code is looked up in that table, and the calibrated time appears one cycle later.

Top module: `tdc_bin_cal`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `out_valid` are low.
- R2: A rising edge of `cal_mode` while idle raises `busy` in the next cycle. Holding `cal_mode` high after the table is finished does not start another pass.
- R3: The histogram accepts `raw_valid` hits only during the learn phase, and exactly 2^`hits_log2` of them. Hits that arrive after the target has been reached, or before clearing has finished, are not counted.
- R4: Each histogram counter stops at 2^CNT_W-1 and does not wrap. A code that receives more hits than that is treated as having exactly 2^CNT_W-1 hits.
- R5: The width of bin c is floor(n_c × PERIOD_PS / 2^`hits_log2`), where n_c is its (saturated) hit count.
- R6: Table entry c equals the sum of the widths of all bins below c plus floor(width_c / 2). An empty bin therefore sits exactly at its lower edge. No entry exceeds PERIOD_PS.
- R7: When the table is complete, `done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R8: In run mode, a `raw_valid` code produces `out_valid` high one cycle later, with `out_time` equal to that code's table entry. Without a lookup, `out_valid` is low.
- R9: While calibrating, `raw_valid` produces no `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_mode | input | 1 | Mode select; a rising edge starts calibration |
| hits_log2 | input | $clog2(MAX_LOG2+1) | Exponent k of the hit target 2^k, sampled at start |
| raw_valid | input | 1 | Raw code strobe (hit while learning, lookup while running) |
| raw_code | input | CODE_W | Raw fine code from the delay line encoder |
| busy | output | 1 | High while a calibration pass is in progress |
| done | output | 1 | One-cycle pulse when the table is complete |
| out_valid | output | 1 | Calibrated result valid |
| out_time | output | $clog2(PERIOD_PS+1) | Calibrated fine time in picoseconds |

## Verification
The checks assume that `hits_log2` never exceeds MAX_LOG2 and stays stable at the start edge. They also assume that raw codes are fully resolved and never X while `raw_valid` is high. The stimulus chooses targets well inside that limit. It makes the hit counts add up to exactly 2^k, and it delivers hits only after the clear pass has ended, with gaps and long runs of one code so that back-to-back updates to the same bin are exercised. Table bounds and `done`/`busy` timing are taken as properties that hold for any hit sequence. The actual entry values are compared against a model that accumulates bin widths.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_LEARN  = 3'd2,
    ST_FLUSH  = 3'd3,
    ST_BUILD  = 3'd4,
    ST_FINISH = 3'd5
  } cal_state_t;
endpackage

// File: rtl/tdc_cal_ram.sv
module tdc_cal_ram #(
  parameter int AW = 6,
  parameter int DW = 16
)(
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // Simple dual port, synchronous read: old data on a same-address collision.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/tdc_cal_hist.sv
module tdc_cal_hist #(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_we,
  input  logic [CODE_W-1:0] clr_addr,
  input  logic              hit_v,
  input  logic [CODE_W-1:0] hit_code,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  logic              s1_v;
  logic [CODE_W-1:0] s1_code;
  logic              wb_v;
  logic [CODE_W-1:0] wb_addr;
  logic [CNT_W-1:0]  wb_data;
  logic [CNT_W-1:0]  ram_q;
  logic [CNT_W-1:0]  base;
  logic [CNT_W-1:0]  bumped;
  logic              we;
  logic [CODE_W-1:0] waddr;
  logic [CNT_W-1:0]  wdata;

  // Forward the value written last cycle when the same bin is read back.
  assign base   = (wb_v && wb_addr == s1_code) ? wb_data : ram_q;
  assign bumped = (&base) ? base : base + 1'b1;

  assign we    = clr_we | s1_v;
  assign waddr = clr_we ? clr_addr : s1_code;
  assign wdata = clr_we ? '0 : bumped;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_code <= '0;
      wb_v    <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
    end else begin
      s1_v    <= hit_v;
      s1_code <= hit_code;
      wb_v    <= s1_v;
      wb_addr <= s1_code;
      wb_data <= bumped;
    end
  end

  tdc_cal_ram #(.AW(CODE_W), .DW(CNT_W)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .re    (hit_v | rd_en),
    .raddr (hit_v ? hit_code : rd_addr),
    .q     (ram_q)
  );

  assign rd_data = ram_q;
endmodule

// File: rtl/tdc_cal_build.sv
module tdc_cal_build #(
  parameter int CNT_W     = 16,
  parameter int PERIOD_PS = 4000,
  parameter int LOGW      = 5,
  parameter int T_W       = 12
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_v,
  input  logic [CNT_W-1:0] cnt,
  input  logic [LOGW-1:0]  shift,
  output logic [T_W-1:0]   centre
);
  localparam int P_W = CNT_W + T_W;

  logic [P_W-1:0] prod;
  logic [T_W:0]   width;
  logic [T_W:0]   acc;

  assign prod   = P_W'(cnt) * P_W'(PERIOD_PS);
  assign width  = (T_W + 1)'(prod >> shift);
  assign centre = T_W'(acc + (width >> 1));

  always_ff @(posedge clk) begin
    if (rst || start) acc <= '0;
    else if (in_v)    acc <= acc + width;
  end
endmodule

// File: rtl/tdc_bin_cal.sv
module tdc_bin_cal
  import tdc_cal_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int CNT_W     = 16,
  parameter int PERIOD_PS = 4000,
  parameter int MAX_LOG2  = 16,
  localparam int LOGW     = $clog2(MAX_LOG2 + 1),
  localparam int T_W      = $clog2(PERIOD_PS + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_mode,
  input  logic [LOGW-1:0]   hits_log2,
  input  logic              raw_valid,
  input  logic [CODE_W-1:0] raw_code,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  output logic [T_W-1:0]    out_time
);
  localparam int NBINS = 1 << CODE_W;
  localparam int TOT_W = MAX_LOG2 + 1;
  localparam logic [CODE_W-1:0] LAST = CODE_W'(NBINS - 1);

  cal_state_t        state;
  logic [CODE_W-1:0] idx;
  logic [TOT_W-1:0]  total;
  logic [TOT_W-1:0]  target;
  logic [LOGW-1:0]   k_q;
  logic              mode_q;
  logic              b_v;
  logic [CODE_W-1:0] b_addr;
  logic              hit_v;
  logic              clr_we;
  logic              bld_re;
  logic              lookup;
  logic [CNT_W-1:0]  bin_cnt;
  logic [T_W-1:0]    centre;

  assign hit_v  = (state == ST_LEARN) && raw_valid;
  assign clr_we = (state == ST_CLEAR);
  assign bld_re = (state == ST_BUILD);
  assign lookup = (state == ST_RUN) && raw_valid;
  assign target = TOT_W'(1) << k_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      idx       <= '0;
      total     <= '0;
      k_q       <= '0;
      mode_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      b_v       <= 1'b0;
      b_addr    <= '0;
      out_valid <= 1'b0;
    end else begin
      mode_q    <= cal_mode;
      done      <= 1'b0;
      b_v       <= bld_re;
      b_addr    <= idx;
      out_valid <= lookup;
      case (state)
        ST_RUN: if (cal_mode && !mode_q) begin
          state <= ST_CLEAR;
          idx   <= '0;
          k_q   <= hits_log2;
          busy  <= 1'b1;
        end
        ST_CLEAR: begin
          idx <= idx + 1'b1;
          if (idx == LAST) begin
            state <= ST_LEARN;
            total <= '0;
          end
        end
        ST_LEARN: if (hit_v) begin
          total <= total + 1'b1;
          if ((total + TOT_W'(1)) == target) state <= ST_FLUSH;
        end
        ST_FLUSH: begin
          state <= ST_BUILD;
          idx   <= '0;
        end
        ST_BUILD: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= ST_FINISH;
        end
        ST_FINISH: begin
          state <= ST_RUN;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  tdc_cal_hist #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (clr_we),
    .clr_addr (idx),
    .hit_v    (hit_v),
    .hit_code (raw_code),
    .rd_en    (bld_re),
    .rd_addr  (idx),
    .rd_data  (bin_cnt)
  );

  tdc_cal_build #(.CNT_W(CNT_W), .PERIOD_PS(PERIOD_PS), .LOGW(LOGW), .T_W(T_W)) u_build (
    .clk    (clk),
    .rst    (rst),
    .start  (state == ST_FLUSH),
    .in_v   (b_v),
    .cnt    (bin_cnt),
    .shift  (k_q),
    .centre (centre)
  );

  tdc_cal_ram #(.AW(CODE_W), .DW(T_W)) u_lut (
    .clk   (clk),
    .we    (b_v),
    .waddr (b_addr),
    .wdata (centre),
    .re    (lookup),
    .raddr (raw_code),
    .q     (out_time)
  );
endmodule

// File: rtl/tdc_bin_cal_chk.sv
module tdc_bin_cal_chk #(
  parameter int PERIOD_PS = 4000,
  parameter int T_W       = 12
)(
  input logic           clk,
  input logic           rst,
  input logic           cal_mode,
  input logic           busy,
  input logic           done,
  input logic           raw_valid,
  input logic           out_valid,
  input logic [T_W-1:0] out_time
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    ($rose(cal_mode) && !busy) |=> busy); // R2

  AST_ENTRY_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (32'(out_time) <= PERIOD_PS)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R7

  AST_OUT_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(raw_valid) && !$past(busy))); // R8

  AST_NO_OUT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !out_valid); // R9
endmodule

bind tdc_bin_cal tdc_bin_cal_chk #(.PERIOD_PS(PERIOD_PS), .T_W(T_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cal_mode  (cal_mode),
  .busy      (busy),
  .done      (done),
  .raw_valid (raw_valid),
  .out_valid (out_valid),
  .out_time  (out_time)
);

// File: tb/test_tdc_bin_cal.sv
`timescale 1ns/1ps
module test_tdc_bin_cal;
  localparam int CODE_W    = 6;
  localparam int CNT_W     = 8;
  localparam int PERIOD_PS = 4000;
  localparam int MAX_LOG2  = 12;
  localparam int LOGW      = $clog2(MAX_LOG2 + 1);
  localparam int T_W       = $clog2(PERIOD_PS + 1);
  localparam int NB        = 1 << CODE_W;
  localparam int SAT       = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cal_mode = 1'b0;
  logic [LOGW-1:0]   hits_log2 = '0;
  logic              raw_valid = 1'b0;
  logic [CODE_W-1:0] raw_code = '0;
  logic              busy;
  logic              done;
  logic              out_valid;
  logic [T_W-1:0]    out_time;

  int checks = 0;
  int errors = 0;
  int cnt  [NB];
  int expv [NB];

  always #2 clk = ~clk;

  tdc_bin_cal #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .PERIOD_PS(PERIOD_PS), .MAX_LOG2(MAX_LOG2)
  ) i_tdc_bin_cal (
    .clk(clk), .rst(rst), .cal_mode(cal_mode), .hits_log2(hits_log2),
    .raw_valid(raw_valid), .raw_code(raw_code), .busy(busy), .done(done),
    .out_valid(out_valid), .out_time(out_time)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Reference: saturated counts, floored widths, centre of each bin (R4 R5 R6)
  task automatic build_model(input int k);
    int acc = 0;
    for (int c = 0; c < NB; c++) begin
      int n = (cnt[c] > SAT) ? SAT : cnt[c];
      int w = (n * PERIOD_PS) >> k;
      expv[c] = acc + w / 2;
      acc += w;
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    chk("R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic feed_hits();
    int maxc = 0;
    int sent = 0;
    for (int c = 0; c < NB; c++) if (cnt[c] > maxc) maxc = cnt[c];
    for (int r = 0; r < maxc; r++) begin
      for (int c = 0; c < NB; c++) begin
        if (r < cnt[c]) begin
          @(negedge clk);
          raw_valid = 1'b1;
          raw_code  = CODE_W'(c);
          sent++;
          if (sent % 13 == 0) begin
            @(negedge clk);
            raw_valid = 1'b0;
          end
        end
      end
    end
    // R3: surplus hits after the target must not be counted
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      raw_valid = 1'b1;
      raw_code  = '0;
    end
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic calibrate(input int k, input string tag);
    int seen = 0;
    @(negedge clk);
    hits_log2 = LOGW'(k);
    cal_mode  = 1'b1;
    @(negedge clk);
    chk({tag, " R2 busy after start"}, busy, 1);
    // R9 and R3: strobes during clearing give no output and are not counted
    for (int i = 0; i < 20; i++) begin
      raw_valid = 1'b1;
      raw_code  = 6'd1;
      @(negedge clk);
      chk({tag, " R9 no out_valid while clearing"}, out_valid, 0);
    end
    raw_valid = 1'b0;
    repeat (60) @(negedge clk);
    feed_hits();
    for (int i = 0; i < 400 && seen == 0; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk({tag, " R7 done seen"}, seen, 1);
    chk({tag, " R7 busy low with done"}, busy, 0);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, done, 0);
    repeat (80) @(negedge clk);
    chk({tag, " R2 no restart while mode held"}, busy, 0);
    cal_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_table(input int k, input string tag);
    build_model(k);
    for (int c = 0; c < NB; c++) begin
      raw_valid = 1'b1;
      raw_code  = CODE_W'(c);
      @(negedge clk);
      chk($sformatf("%s R8 out_valid code %0d", tag, c), out_valid, 1);
      chk($sformatf("%s R6 entry code %0d", tag, c), out_time, expv[c]);
    end
    raw_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R8 out_valid idle"}, out_valid, 0);
  endtask

  // Non-uniform spread with empty bins and one wide bin; sums to 1024
  task automatic test_nonuniform();
    int sum = 0;
    for (int c = 0; c < NB; c++) begin
      cnt[c] = (c % 7 == 3) ? 0 : 8 + 2 * (c % 9);
      sum += cnt[c];
    end
    cnt[11] += 1024 - sum;
    calibrate(10, "nonuniform");
    check_table(10, "nonuniform");
  endtask

  // R4: two bins overflow an 8-bit counter and must saturate
  task automatic test_saturation();
    for (int c = 0; c < NB; c++) cnt[c] = 0;
    cnt[5] = 300;
    cnt[6] = 724;
    calibrate(10, "saturate");
    check_table(10, "saturate");
    chk("saturate R4 bin 6 centre", expv[6], 1494);
  endtask

  // Small target: four hits with k=2, full-period widths
  task automatic test_small();
    for (int c = 0; c < NB; c++) cnt[c] = 0;
    cnt[0]  = 1;
    cnt[40] = 2;
    cnt[63] = 1;
    calibrate(2, "small");
    check_table(2, "small");
  endtask

  initial begin
    test_reset();
    test_nonuniform();
    test_saturation();
    test_small();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule